// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Clock Stretching

This block produces the serial clock of an I2C master from the system clock. A 6-bit divider code picks the division ratio from a fixed two-half table. Inside the block each ratio is a power-of-two sample prescaler times a whole number of samples per bit. The SCL line is driven open-drain: the block either pulls it low or releases it. The level of the line is read only on prescaler strobes, after a two-flop synchronizer.

Each bit starts with a low phase of fixed length. The block then releases the line and counts the high phase only on strobes where the synchronized line reads high. A slave that holds SCL low can therefore stall the bit for as long as it likes. A slow rising edge also stretches the bit, by a whole number of sample periods. Two codes with the same nominal ratio but a different prescaler react differently to the same rise time.

A one-cycle bit tick marks the start of every bit. It lets the byte-level engine, or a bench, step through bits and measure the period. A new divider code is applied only at a bit boundary.

Top module: `i2c_scl_gen`

## Requirements
- R1: Codes 0x00..0x1F: codes 0x00..0x0C map to (prescale P, samples S) = (2,14),(2,15),(2,17),(4,10),(4,11),(4,12),(4,14),(4,17),(8,10),(8,11),(8,13),(8,16),(8,18). For code c in 0x0D..0x1F, with k=c-0x0D, P=16·2^(k/4) and S is 10,12,15,18 for k mod 4 = 0,1,2,3 (so 0x0D = 16×10 and 0x0E = 16×12).
- R2: Codes 0x20..0x3F: codes 0x20..0x2B map to (2,10),(2,11),(2,12),(2,13),(2,14),(2,16),(2,18),(4,10),(4,12),(4,14),(4,16),(4,18). For code c in 0x2C..0x3F, with k=c-0x2C, P=16·2^(k/4) and S=5+(k mod 4) (so 0x30 = 32×5 and 0x31 = 32×6).
- R3: The line is sampled every P system clocks, through a two-stage synchronizer. If the line reaches high R clocks after release, the high phase misses m = ceil((R+3)/P)-1 strobes, and the bit period becomes (S+m)·P clocks. With an instant rise this gives S·P for P≥4 and S·P+2 for P=2.
- R4: In each bit, the pull-low output is asserted for exactly floor(S/2)·P consecutive system clocks, starting with the bit.
- R5: While the synchronized line reads low in the high phase, the high-phase count does not advance and no bit tick is produced, for any length of time. The block keeps the line released meanwhile.
- R6: The bit tick is a single-cycle pulse. It coincides with the first clock of each low phase, so the spacing between ticks equals the bit period.
- R7: A divider-code change during a bit does not alter that bit. It applies from the next bit onward.
- R8: When enable is low, the line is released and no ticks occur. A later enable starts a fresh bit from cleared counters, and the first tick follows (S+m)·P+1 clocks after enable is applied at a falling edge.
- R9: During reset the line is released and the bit tick is low, whatever the enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock; low releases SCL and clears state |
| divCode | input | 6 | Divider code, sampled at bit boundaries |
| sclIn | input | 1 | Sensed level of the SCL line |
| sclPullLow | output | 1 | 1 = drive SCL low, 0 = release |
| bitTick | output | 1 | One-cycle pulse at the start of each bit |

## Verification
The bench targets the code pairs that share a nominal ratio (160 and 192), under both an instant and a 20-clock rise. A design that used the same prescaler for both members of a pair would show identical stretch, where one should grow by a full sample period and the other should not. Prescale-2 codes expose the synchronizer latency: a design that sampled the raw line, or used the wrong number of stages, would lose the extra strobe. An indefinite slave hold, a mid-bit code change and a mid-bit disable check for counting while low, switching ratio inside a bit, and leftover counter state on restart.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

  localparam int CODE_W    = 6;
  localparam int MAX_SHIFT = 8;   // largest prescale is 2^8
  localparam int MAX_SAMP  = 18;  // largest samples-per-bit
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int SAMP_W    = $clog2(MAX_SAMP + 1);
  localparam int PC_W      = MAX_SHIFT;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} sclState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // clear prescaler and phase counter
    logic load;     // capture divider code
    logic count;    // advance phase counter
    logic restart;  // zero phase counter for next phase
  } sclCtl_t;

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;
    logic [SAMP_W-1:0]  samples;
  } divSel_t;

  function automatic divSel_t decodeDiv(input logic [CODE_W-1:0] code);
    divSel_t d;
    int sh;
    int sm;
    int k;
    sh = 1;
    sm = 10;
    k  = 0;
    if (code < 6'h0D) begin
      case (code[3:0])
        4'd0:  begin sh = 1; sm = 14; end
        4'd1:  begin sh = 1; sm = 15; end
        4'd2:  begin sh = 1; sm = 17; end
        4'd3:  begin sh = 2; sm = 10; end
        4'd4:  begin sh = 2; sm = 11; end
        4'd5:  begin sh = 2; sm = 12; end
        4'd6:  begin sh = 2; sm = 14; end
        4'd7:  begin sh = 2; sm = 17; end
        4'd8:  begin sh = 3; sm = 10; end
        4'd9:  begin sh = 3; sm = 11; end
        4'd10: begin sh = 3; sm = 13; end
        4'd11: begin sh = 3; sm = 16; end
        default: begin sh = 3; sm = 18; end
      endcase
    end else if (code < 6'h20) begin
      k  = int'(code) - 13;
      sh = 4 + k / 4;
      case (k % 4)
        0:       sm = 10;
        1:       sm = 12;
        2:       sm = 15;
        default: sm = 18;
      endcase
    end else if (code < 6'h2C) begin
      case (code[3:0])
        4'd0:  begin sh = 1; sm = 10; end
        4'd1:  begin sh = 1; sm = 11; end
        4'd2:  begin sh = 1; sm = 12; end
        4'd3:  begin sh = 1; sm = 13; end
        4'd4:  begin sh = 1; sm = 14; end
        4'd5:  begin sh = 1; sm = 16; end
        4'd6:  begin sh = 1; sm = 18; end
        4'd7:  begin sh = 2; sm = 10; end
        4'd8:  begin sh = 2; sm = 12; end
        4'd9:  begin sh = 2; sm = 14; end
        4'd10: begin sh = 2; sm = 16; end
        default: begin sh = 2; sm = 18; end
      endcase
    end else begin
      k  = int'(code) - 44;
      sh = 4 + k / 4;
      sm = 5 + k % 4;
    end
    d.shift   = SHIFT_W'(sh);
    d.samples = SAMP_W'(sm);
    return d;
  endfunction

endpackage

// File: rtl/sclg_datapath.sv
module sclg_datapath
  import sclg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] divCode,
  input  logic              sclIn,
  input  sclCtl_t           ctl,
  output logic              sampleStb,
  output logic              sclSeenHigh,
  output logic              lastLow,
  output logic              lastHigh,
  output logic [CODE_W-1:0] curCode
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [PC_W-1:0]        presCnt;
  logic [PC_W-1:0]        presLast;
  logic [SAMP_W-1:0]      phaseCnt;
  logic [SAMP_W-1:0]      lowLen;
  logic [SAMP_W-1:0]      highLen;
  divSel_t                sel;

  // line synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
  end
  assign sclSeenHigh = syncQ[SYNC_STAGES-1];

  // active divider code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        curCode <= '0;
    else if (ctl.load) curCode <= divCode;
  end

  assign sel      = decodeDiv(curCode);
  assign presLast = PC_W'(((PC_W+1)'(1) << sel.shift) - (PC_W+1)'(1));
  assign lowLen   = sel.samples >> 1;
  assign highLen  = sel.samples - lowLen;

  // sample prescaler
  assign sampleStb = (presCnt == presLast);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      presCnt <= '0;
    else if (ctl.clear || sampleStb) presCnt <= '0;
    else                             presCnt <= presCnt + PC_W'(1);
  end

  // phase sample counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        phaseCnt <= '0;
    else if (ctl.clear || ctl.restart) phaseCnt <= '0;
    else if (ctl.count)                phaseCnt <= phaseCnt + SAMP_W'(1);
  end

  assign lastLow  = (phaseCnt == lowLen  - SAMP_W'(1));
  assign lastHigh = (phaseCnt == highLen - SAMP_W'(1));

endmodule

// File: rtl/sclg_control.sv
module sclg_control
  import sclg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    sampleStb,
  input  logic    sclSeenHigh,
  input  logic    lastLow,
  input  logic    lastHigh,
  output sclCtl_t ctl,
  output logic    sclPullLow,
  output logic    bitTick
);

  sclState_t state;
  sclState_t stateNxt;
  logic      tickNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    tickNxt  = 1'b0;
    if (!enable) begin
      ctl.clear = 1'b1;
      stateNxt  = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          ctl.clear = 1'b1;
          ctl.load  = 1'b1;
          stateNxt  = ST_LOW;
        end
        ST_LOW: begin
          if (sampleStb) begin
            if (lastLow) begin
              ctl.restart = 1'b1;
              stateNxt    = ST_HIGH;
            end else begin
              ctl.count = 1'b1;
            end
          end
        end
        default: begin
          // high phase advances only on strobes that see the line high
          if (sampleStb && sclSeenHigh) begin
            if (lastHigh) begin
              ctl.restart = 1'b1;
              ctl.load    = 1'b1;
              tickNxt     = 1'b1;
              stateNxt    = ST_LOW;
            end else begin
              ctl.count = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitTick <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitTick <= tickNxt;
    end
  end

  assign sclPullLow = (state == ST_LOW);

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import sclg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] divCode,
  input  logic              sclIn,
  output logic              sclPullLow,
  output logic              bitTick
);

  sclCtl_t           ctl;
  logic              sampleStb;
  logic              sclSeenHigh;
  logic              lastLow;
  logic              lastHigh;
  logic [CODE_W-1:0] curCode;

  sclg_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .divCode(divCode), .sclIn(sclIn), .ctl(ctl),
    .sampleStb(sampleStb), .sclSeenHigh(sclSeenHigh), .lastLow(lastLow),
    .lastHigh(lastHigh), .curCode(curCode)
  );

  sclg_control u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sampleStb(sampleStb),
    .sclSeenHigh(sclSeenHigh), .lastLow(lastLow), .lastHigh(lastHigh),
    .ctl(ctl), .sclPullLow(sclPullLow), .bitTick(bitTick)
  );

endmodule

// File: rtl/sclg_checker.sv
module sclg_checker
  import sclg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              sclIn,
  input logic              sclPullLow,
  input logic              bitTick,
  input logic [CODE_W-1:0] curCode
);

  logic [1:0] upCnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              upCnt <= '0;
    else if (upCnt != 2'd3)  upCnt <= upCnt + 2'd1;
  end
  assign armed = (upCnt == 2'd3);

  p_tick_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bitTick |=> !bitTick);

  p_tick_starts_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bitTick |-> sclPullLow);

  p_off_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sclPullLow && !bitTick));

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && enable && $past(enable) && $past(enable, 2) && !bitTick) |-> $stable(curCode));

  p_tick_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bitTick) |-> $past(sclIn, 3));

endmodule

bind i2c_scl_gen sclg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sclIn(sclIn),
  .sclPullLow(sclPullLow), .bitTick(bitTick), .curCode(curCode)
);

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [5:0]  divCode = 6'h0E;
  logic        sclIn;
  logic        sclPullLow;
  logic        bitTick;
  logic        holdLow = 1'b0;
  int          riseDly = 0;
  int          riseCnt = 0;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_scl_gen u_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divCode(divCode),
    .sclIn(sclIn), .sclPullLow(sclPullLow), .bitTick(bitTick)
  );

  // open-drain line model with programmable rise delay and slave hold
  always @(negedge clk) riseCnt <= sclPullLow ? 0 : riseCnt + 1;
  assign sclIn = !sclPullLow && (riseCnt > riseDly) && !holdLow;

  // {code, rise delay, expected period, expected low clocks}
  localparam logic [63:0] VEC [17] = '{
    {16'h0E, 16'd0,   16'd192,  16'd96},
    {16'h31, 16'd0,   16'd192,  16'd96},
    {16'h0D, 16'd0,   16'd160,  16'd80},
    {16'h30, 16'd0,   16'd160,  16'd64},
    {16'h0E, 16'd20,  16'd208,  16'd96},
    {16'h31, 16'd20,  16'd192,  16'd96},
    {16'h0D, 16'd20,  16'd176,  16'd80},
    {16'h30, 16'd20,  16'd160,  16'd64},
    {16'h00, 16'd0,   16'd30,   16'd14},
    {16'h00, 16'd6,   16'd36,   16'd14},
    {16'h20, 16'd0,   16'd22,   16'd10},
    {16'h03, 16'd0,   16'd40,   16'd20},
    {16'h1F, 16'd0,   16'd3840, 16'd1792},
    {16'h3F, 16'd0,   16'd2048, 16'd1024},
    {16'h2C, 16'd0,   16'd80,   16'd32},
    {16'h26, 16'd0,   16'd38,   16'd18},
    {16'h0E, 16'd100, 16'd288,  16'd96}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTick();
    int n = 0;
    while (!bitTick && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int per, output int low);
    waitTick();
    per = 0;
    low = 0;
    do begin
      if (sclPullLow) low++;
      per++;
      @(negedge clk);
    end while (!bitTick && per < 20000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int per;
    int low;
    int n;
    int ticks;
    string req;

    // R9: reset holds the line released even with enable high
    enable = 1'b1;
    repeat (5) @(negedge clk);
    check(!sclPullLow && !bitTick, "R9 reset outputs", {sclPullLow, bitTick}, 0);
    rst_n = 1'b1;
    enable = 1'b0;
    @(negedge clk);

    // table walk: R1/R2 ratios, R3 rise quantisation, R4 low length
    for (int i = 0; i < 17; i++) begin
      enable = 1'b0;
      divCode = VEC[i][53:48];
      riseDly = int'(VEC[i][47:32]);
      repeat (3) @(negedge clk);
      enable = 1'b1;
      measure(per, low);
      if (riseDly > 0)            req = "R3 period";
      else if (divCode < 6'h20)   req = "R1 period";
      else                        req = "R2 period";
      check(per == int'(VEC[i][31:16]), req, per, int'(VEC[i][31:16]));
      check(low == int'(VEC[i][15:0]), "R4 low clocks", low, int'(VEC[i][15:0]));
    end

    // R6: tick lasts a single cycle
    enable = 1'b0;
    divCode = 6'h03;
    riseDly = 0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    waitTick();
    @(negedge clk);
    check(!bitTick, "R6 tick width", bitTick, 0);

    // R5: slave holds SCL low indefinitely
    waitTick();
    holdLow = 1'b1;
    ticks = 0;
    repeat (1000) begin
      @(negedge clk);
      if (bitTick) ticks++;
    end
    check(ticks == 0, "R5 ticks during hold", ticks, 0);
    check(!sclPullLow, "R5 released during hold", sclPullLow, 0);
    holdLow = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitTick && n < 1000);
    check(n >= 20 && n <= 28, "R5 resume after hold", n, 24);

    // R7: code change mid-bit applies at the next bit
    enable = 1'b0;
    divCode = 6'h0E;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    waitTick();
    per = 0;
    do begin
      if (per == 5) divCode = 6'h30;
      per++;
      @(negedge clk);
    end while (!bitTick && per < 20000);
    check(per == 192, "R7 current bit keeps old code", per, 192);
    measure(per, low);
    check(per == 160, "R7 next bit uses new code", per, 160);

    // R8: disable mid-bit, then restart from cleared counters
    divCode = 6'h0E;
    waitTick();
    repeat (250) @(negedge clk);
    waitTick();
    repeat (50) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!sclPullLow, "R8 released on disable", sclPullLow, 0);
    ticks = 0;
    repeat (300) begin
      @(negedge clk);
      if (bitTick || sclPullLow) ticks++;
    end
    check(ticks == 0, "R8 quiet while disabled", ticks, 0);
    enable = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitTick && n < 1000);
    check(n == 193, "R8 first tick after restart", n, 193);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule